// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of an accumulator-based 8-bit processor. Each cycle it takes an operation code, the accumulator value, a second operand, a carry input and a code naming where the second operand came from. From these it produces the 8-bit result and six condition flags: sign, zero, half-carry, parity/overflow, subtract and carry. It also reports how many T-states the instruction takes. The operation set is bitwise AND, OR and XOR, add with carry, subtract with carry, and two's-complement negation of the accumulator.

The parity/overflow flag serves two purposes. After a bitwise operation it marks an even count of one bits in the result. After an arithmetic operation it marks signed overflow. All outputs are registered, so the values for the inputs presented in one cycle appear after the next rising clock edge. An active-low reset clears every output to zero. Flag bits 3 and 5 of a processor flag byte, operand fetch and the register file belong to other blocks.

Top module: `alu8_flag_core`

## Requirements
- R1: Operation codes are 0 AND, 1 OR, 2 XOR, 3 add-with-carry, 4 subtract-with-carry and 5 negate. For codes 0 to 2 the result is the bitwise function of accumulator and operand, and the carry input has no effect.
- R2: After AND the half-carry flag is 1 and the subtract and carry flags are 0. After OR and XOR the half-carry, subtract and carry flags are all 0.
- R3: After a bitwise operation, parity/overflow is 1 exactly when the result holds an even number of one bits (a zero result counts as even). Sign equals result bit 7, and zero is 1 exactly when the result is 0x00.
- R4: Add-with-carry yields (A + B + cin) mod 256. Carry is the carry out of bit 7, half-carry is the carry out of bit 3, and subtract is 0.
- R5: Subtract-with-carry yields (A - B - cin) mod 256. Carry is 1 when a borrow leaves bit 7, half-carry is 1 when a borrow comes into bit 4, and subtract is 1.
- R6: For add and subtract, parity/overflow is the signed two's-complement overflow of the 8-bit operation. Sign and zero follow the result as in R3.
- R7: Negate yields (0 - A) mod 256 and ignores the operand and the carry input. Subtract is 1, carry is 1 when A is non-zero, half-carry is 1 when A's low nibble is non-zero, and parity/overflow is 1 only for A = 0x80.
- R8: Source codes are 0 register, 1 immediate, 2 memory through the HL pointer, and 3 treated as memory. The T-state output is 4 for a register source and 7 for the other sources. Negate reports 8 whatever the source.
- R9: Codes 6 and 7 are unused. They give a 0x00 result with every flag 0, and the T-state count follows the source as in R8.
- R10: The outputs change only at a rising clock edge, one edge after their inputs. While reset is active, the result, every flag and the T-state output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 3 | Operation code (R1) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| carry_in | input | 1 | Carry/borrow input for add and subtract |
| src_sel | input | 2 | Operand source code (R8) |
| result_q | output | 8 | Registered result |
| sign_q | output | 1 | Sign flag |
| zero_q | output | 1 | Zero flag |
| half_q | output | 1 | Half-carry flag |
| parity_ovf_q | output | 1 | Parity or overflow flag |
| sub_q | output | 1 | Subtract flag |
| carry_q | output | 1 | Carry flag |
| tstates_q | output | 4 | Instruction T-state count |

## Verification
The assertions check, on every cycle, properties that link the inputs to the registered outputs one edge later. These are the fixed flags of AND, OR and XOR, the 8-state count of negate, the 4-state count for register operands, the carry of negating zero, and the zero flag that subtracting equal values sets. The exact arithmetic results, the half-carry and overflow boundaries (0x7F plus a carry, 0x80 minus 1, negating 0x80) and the parity of individual results depend on data values. Only the bench's chosen operand pairs show those.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned OP_W  = 3;
    localparam int unsigned SRC_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_XOR = 3'd2,
        OP_ADC = 3'd3,
        OP_SBC = 3'd4,
        OP_NEG = 3'd5,
        OP_RS6 = 3'd6,
        OP_RS7 = 3'd7
    } alu_op_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_REG = 2'd0,
        SRC_IMM = 2'd1,
        SRC_MEM = 2'd2,
        SRC_RSV = 2'd3
    } opnd_src_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } cond_flags_t;

endpackage

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit
    import alu8_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output cond_flags_t       flags
);
    logic [DATA_W-1:0] and_v;
    logic [DATA_W-1:0] or_v;
    logic [DATA_W-1:0] xor_v;

    // One gate per bit position for each function.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign and_v[i] = a[i] & b[i];
        assign or_v[i]  = a[i] | b[i];
        assign xor_v[i] = a[i] ^ b[i];
    end

    always_comb begin
        unique case (alu_op_e'(op))
            OP_AND:  res = and_v;
            OP_OR:   res = or_v;
            default: res = xor_v;
        endcase
        flags.s  = res[DATA_W-1];
        flags.z  = (res == '0);
        flags.h  = (alu_op_e'(op) == OP_AND);
        flags.pv = ~(^res);
        flags.n  = 1'b0;
        flags.c  = 1'b0;
    end
endmodule

// File: rtl/alu8_arith_unit.sv
module alu8_arith_unit #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    input  logic              is_sub,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              h_out,
    output logic              v_out
);
    localparam int unsigned HALF_W = DATA_W / 2;

    logic [DATA_W:0] full_v;
    logic [HALF_W:0] low_v;

    always_comb begin
        if (is_sub) begin
            full_v = {1'b0, x} - {1'b0, y} - {{DATA_W{1'b0}}, cin};
            low_v  = {1'b0, x[HALF_W-1:0]} - {1'b0, y[HALF_W-1:0]}
                   - {{HALF_W{1'b0}}, cin};
        end else begin
            full_v = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
            low_v  = {1'b0, x[HALF_W-1:0]} + {1'b0, y[HALF_W-1:0]}
                   + {{HALF_W{1'b0}}, cin};
        end
        res   = full_v[DATA_W-1:0];
        c_out = full_v[DATA_W];
        h_out = low_v[HALF_W];
        // Overflow: operand signs agree (add) or differ (sub) and result sign leaves x's.
        v_out = ((x[DATA_W-1] ^ y[DATA_W-1]) == is_sub)
              && (res[DATA_W-1] != x[DATA_W-1]);
    end
endmodule

// File: rtl/alu8_cycle_count.sv
module alu8_cycle_count
    import alu8_pkg::*;
#(
    parameter int unsigned TST_W = 4,
    parameter int unsigned T_REG = 4,
    parameter int unsigned T_MEM = 7,
    parameter int unsigned T_NEG = 8
) (
    input  logic [OP_W-1:0]  op,
    input  logic [SRC_W-1:0] src,
    output logic [TST_W-1:0] tst
);
    always_comb begin
        if (alu_op_e'(op) == OP_NEG) begin
            tst = TST_W'(T_NEG);
        end else if (opnd_src_e'(src) == SRC_REG) begin
            tst = TST_W'(T_REG);
        end else begin
            tst = TST_W'(T_MEM);
        end
    end
endmodule

// File: rtl/alu8_flag_core.sv
module alu8_flag_core
    import alu8_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned TST_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              carry_in,
    input  logic [1:0]        src_sel,
    output logic [DATA_W-1:0] result_q,
    output logic              sign_q,
    output logic              zero_q,
    output logic              half_q,
    output logic              parity_ovf_q,
    output logic              sub_q,
    output logic              carry_q,
    output logic [TST_W-1:0]  tstates_q
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        cond_flags_t       fl;
        logic [TST_W-1:0]  tst;
    } core_state_t;

    core_state_t st_d, st_q;

    alu_op_e op_e;
    assign op_e = alu_op_e'(op_sel);

    logic [DATA_W-1:0] lg_res;
    cond_flags_t       lg_fl;

    alu8_logic_unit #(.DATA_W(DATA_W)) u_logic (
        .op    (op_sel),
        .a     (acc_in),
        .b     (opnd_in),
        .res   (lg_res),
        .flags (lg_fl)
    );

    // Negate runs through the subtractor as 0 - A with no borrow in.
    logic              is_neg;
    logic [DATA_W-1:0] ar_x, ar_y, ar_res;
    logic              ar_cin, ar_sub, ar_c, ar_h, ar_v;

    assign is_neg = (op_e == OP_NEG);
    assign ar_x   = is_neg ? '0 : acc_in;
    assign ar_y   = is_neg ? acc_in : opnd_in;
    assign ar_cin = is_neg ? 1'b0 : carry_in;
    assign ar_sub = (op_e != OP_ADC);

    alu8_arith_unit #(.DATA_W(DATA_W)) u_arith (
        .x      (ar_x),
        .y      (ar_y),
        .cin    (ar_cin),
        .is_sub (ar_sub),
        .res    (ar_res),
        .c_out  (ar_c),
        .h_out  (ar_h),
        .v_out  (ar_v)
    );

    logic [TST_W-1:0] cc_tst;

    alu8_cycle_count #(.TST_W(TST_W)) u_cycles (
        .op  (op_sel),
        .src (src_sel),
        .tst (cc_tst)
    );

    always_comb begin
        st_d     = '0;
        st_d.tst = cc_tst;
        unique case (op_e)
            OP_AND, OP_OR, OP_XOR: begin
                st_d.res = lg_res;
                st_d.fl  = lg_fl;
            end
            OP_ADC, OP_SBC, OP_NEG: begin
                st_d.res  = ar_res;
                st_d.fl.s = ar_res[DATA_W-1];
                st_d.fl.z = (ar_res == '0);
                st_d.fl.h = ar_h;
                st_d.fl.pv = ar_v;
                st_d.fl.n = ar_sub;
                st_d.fl.c = ar_c;
            end
            default: begin
                st_d.res = '0;
                st_d.fl  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_q     = st_q.res;
    assign sign_q       = st_q.fl.s;
    assign zero_q       = st_q.fl.z;
    assign half_q       = st_q.fl.h;
    assign parity_ovf_q = st_q.fl.pv;
    assign sub_q        = st_q.fl.n;
    assign carry_q      = st_q.fl.c;
    assign tstates_q    = st_q.tst;

    // Assertions guarding the flag and cycle outputs.
    assert_and_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd0) |=> (half_q && !sub_q && !carry_q));

    assert_or_xor_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd1 || op_sel == 3'd2) |=> (!half_q && !sub_q && !carry_q));

    assert_neg_tstates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd5) |=> (tstates_q == TST_W'(8)));

    assert_reg_tstates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != 3'd5 && src_sel == 2'd0) |=> (tstates_q == TST_W'(4)));

    assert_neg_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd5 && acc_in == '0) |=> (!carry_q && zero_q && sub_q));

    assert_sub_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd4 && acc_in == opnd_in && !carry_in) |=> (zero_q && !carry_q && sub_q));

    assert_unused_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel[2:1] == 2'b11) |=> (result_q == '0 && !carry_q && !half_q && !zero_q));
endmodule

// File: tb/alu8_flag_core_tb_top.sv
module alu8_flag_core_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic       carry_in = 1'b0;
    logic [1:0] src_sel = '0;
    logic [7:0] result_q;
    logic       sign_q, zero_q, half_q, parity_ovf_q, sub_q, carry_q;
    logic [3:0] tstates_q;

    always #(CLK_PERIOD / 2) clk = ~clk;

    alu8_flag_core dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_sel       (op_sel),
        .acc_in       (acc_in),
        .opnd_in      (opnd_in),
        .carry_in     (carry_in),
        .src_sel      (src_sel),
        .result_q     (result_q),
        .sign_q       (sign_q),
        .zero_q       (zero_q),
        .half_q       (half_q),
        .parity_ovf_q (parity_ovf_q),
        .sub_q        (sub_q),
        .carry_q      (carry_q),
        .tstates_q    (tstates_q)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [17:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    function automatic logic [17:0] observed();
        return {result_q, sign_q, zero_q, half_q, parity_ovf_q, sub_q, carry_q, tstates_q};
    endfunction

    // Flags given in the order s z h pv n c.
    task automatic drive(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic ci, input logic [1:0] src,
                         input logic [7:0] e_res, input logic [5:0] e_fl,
                         input logic [3:0] e_t, input string tag);
        @(negedge clk);
        op_sel = op; acc_in = a; opnd_in = b; carry_in = ci; src_sel = src;
        exp_q.push_back({e_res, e_fl, e_t});
        tag_q.push_back(tag);
    endtask

    // Monitor: pops one expectation per edge, sampled after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [17:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (observed() !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual res=%h flags(szhpnc)=%b t=%0d expected res=%h flags=%b t=%0d",
                             t, observed()[17:10], observed()[9:4], observed()[3:0],
                             e[17:10], e[9:4], e[3:0]);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // Reset state (R10): drive non-trivial inputs while held in reset.
        op_sel = 3'd5; acc_in = 8'h01; src_sel = 2'd1;
        repeat (3) @(posedge clk);
        #2;
        n_cmp++;
        if (observed() !== 18'd0) begin
            n_bad++;
            $display("FAIL R10 reset: actual=%h expected=%h", observed(), 18'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Bitwise operations, carry in set to show it is ignored.
        drive(3'd0, 8'hF0, 8'h3C, 1'b1, 2'd0, 8'h30, 6'b001100, 4'd4, "R1 R2 R3 R8 and reg");
        drive(3'd0, 8'h0F, 8'hF0, 1'b1, 2'd1, 8'h00, 6'b011100, 4'd7, "R1 R2 R3 and zero imm");
        drive(3'd1, 8'h80, 8'h01, 1'b1, 2'd2, 8'h81, 6'b100100, 4'd7, "R1 R2 R3 or mem");
        drive(3'd2, 8'h55, 8'h55, 1'b0, 2'd0, 8'h00, 6'b010100, 4'd4, "R1 R3 xor zero");
        drive(3'd2, 8'h01, 8'h00, 1'b1, 2'd3, 8'h01, 6'b000000, 4'd7, "R3 R8 xor odd parity src3");
        // Add with carry.
        drive(3'd3, 8'h22, 8'h77, 1'b0, 2'd0, 8'h99, 6'b100100, 4'd4, "R4 R6 adc overflow");
        drive(3'd3, 8'hFF, 8'h00, 1'b1, 2'd0, 8'h00, 6'b011001, 4'd4, "R4 adc wrap carry");
        drive(3'd3, 8'h0F, 8'h01, 1'b0, 2'd1, 8'h10, 6'b001000, 4'd7, "R4 adc half carry");
        drive(3'd3, 8'h7F, 8'h00, 1'b1, 2'd0, 8'h80, 6'b101100, 4'd4, "R4 R6 adc carry-in overflow");
        // Subtract with carry.
        drive(3'd4, 8'h40, 8'h3F, 1'b0, 2'd0, 8'h01, 6'b001010, 4'd4, "R5 sbc");
        drive(3'd4, 8'h40, 8'h44, 1'b0, 2'd0, 8'hFC, 6'b101011, 4'd4, "R5 R6 sbc negative");
        drive(3'd4, 8'h44, 8'h44, 1'b0, 2'd0, 8'h00, 6'b010010, 4'd4, "R5 R6 sbc zero");
        drive(3'd4, 8'h80, 8'h01, 1'b0, 2'd2, 8'h7F, 6'b001110, 4'd7, "R5 R6 sbc overflow");
        drive(3'd4, 8'h44, 8'h43, 1'b1, 2'd0, 8'h00, 6'b010010, 4'd4, "R5 sbc borrow in");
        // Negate, operand and carry in deliberately non-zero.
        drive(3'd5, 8'h80, 8'hAA, 1'b1, 2'd1, 8'h80, 6'b100111, 4'd8, "R7 R8 neg 0x80");
        drive(3'd5, 8'h00, 8'h55, 1'b1, 2'd0, 8'h00, 6'b010010, 4'd8, "R7 neg zero");
        drive(3'd5, 8'h01, 8'hFF, 1'b0, 2'd2, 8'hFF, 6'b101011, 4'd8, "R7 neg one");
        // Unused codes.
        drive(3'd6, 8'hFF, 8'hFF, 1'b1, 2'd0, 8'h00, 6'b000000, 4'd4, "R9 code 6");
        drive(3'd7, 8'h80, 8'h80, 1'b1, 2'd1, 8'h00, 6'b000000, 4'd7, "R9 code 7");
        // Hold inputs: output stays put across further edges (R10).
        drive(3'd7, 8'h80, 8'h80, 1'b1, 2'd1, 8'h00, 6'b000000, 4'd7, "R10 hold");

        @(negedge clk);
        op_sel = 3'd0;
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule